// File: doc/BRIEF.md
# Byte-to-Halfword Clock-Crossing Capture Buffer

This block takes a byte stream clocked by an external source and hands it to a consumer on the system clock as 16-bit words. The two clocks are unrelated. Bytes are paired on the source side before the crossing, so the storage behind the crossing is written once per two input bytes. A source at 125 MHz therefore writes the queue at 62.5 MHz.

Packed words go into a circular queue with a power-of-two depth. The write and read pointers cross between the domains as Gray codes through two-flop synchronizers. The consumer drains the queue with a valid/ready handshake at its own pace. A burst is absorbed as long as the queue has room. The source is never stalled. A word that finds the queue full is discarded, and a sticky overflow flag is set. The consumer clears that flag with a one-cycle clear pulse, which crosses into the source domain.

A single unpaired byte waits in the packing register until its partner arrives. It is never flushed on its own.

Top module: `cdc_pack_fifo`

## Requirements
- R1: After reset, empty_o=1, full_o=0, ovf_o=0 and word_valid_o=0.
- R2: The first byte of each pair lands in word bits [7:0] and the second byte in bits [15:8].
- R3: With no overflow, every packed word reaches the consumer exactly once and in arrival order, whatever the backpressure pattern on word_ready_i.
- R4: full_o is 1 while DEPTH words (default 16) are stored and unread, and returns to 0 once the consumer has drained words.
- R5: A word that completes while full_o=1 is discarded, the words already stored stay intact, and ovf_o becomes 1.
- R6: ovf_o stays 1 until the consumer pulses ovf_clr_i. After that pulse, and the synchronizer latency, ovf_o returns to 0.
- R7: A lone byte produces no word. The word appears only once a second byte arrives.
- R8: empty_o is 1 exactly when no word is available, and word_valid_o always equals the inverse of empty_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | External source clock |
| rclk_i | input | 1 | System (consumer) clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| byte_valid_i | input | 1 | Byte strobe, source domain |
| byte_data_i | input | 8 | Byte value, source domain |
| full_o | output | 1 | Queue full, source domain |
| word_valid_o | output | 1 | Word available, system domain |
| word_data_o | output | 16 | Head word, system domain |
| word_ready_i | input | 1 | Consumer accepts head word |
| empty_o | output | 1 | Queue empty, system domain |
| ovf_o | output | 1 | Sticky overflow flag, synchronized into the system domain |
| ovf_clr_i | input | 1 | One-cycle pulse that clears the overflow flag, system domain |

## Verification
The bench checks byte order inside each word under three ready patterns. A packer with the halves swapped would return every word byte-reversed. It stalls the consumer and sends four words more than the queue holds. A pointer comparison off by one would either overwrite a stored word or drop a word early, which shows up as a mismatch against the scoreboard. It leaves one byte unpaired for a long stretch to catch a packer that emits half-filled words. It also confirms that the overflow flag survives idle time and falls only after the clear pulse, which exposes a flag that is not sticky or a clear that never crosses.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/cpf_sync.sv
module cpf_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/cpf_packer.sv
module cpf_packer
  import cpf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  byte_valid_i,
  input  byte_t byte_data_i,
  output logic  word_valid_o,
  output word_t word_data_o
);
  logic  have_q;
  byte_t lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q       <= 1'b0;
      lo_q         <= '0;
      word_valid_o <= 1'b0;
      word_data_o  <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (byte_valid_i) begin
        if (have_q) begin
          word_valid_o <= 1'b1;
          word_data_o  <= {byte_data_i, lo_q};
          have_q       <= 1'b0;
        end else begin
          lo_q   <= byte_data_i;
          have_q <= 1'b1;
        end
      end
    end
  end

  // each word needs two bytes, so words never come back to back
  assert_pack_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);
endmodule

// File: rtl/cpf_wside.sv
module cpf_wside
  import cpf_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PTR_W-1:0]  rgray_i,
  input  logic              clr_tgl_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [PTR_W-1:0]  wgray_o,
  output logic              full_o,
  output logic              ovf_o
);
  logic [PTR_W-1:0] wbin_q, wbin_nx;
  logic             clr_d_q, clr_edge;

  // full: top two bits inverted, the rest equal
  assign full_o   = (wgray_o == {~rgray_i[PTR_W-1:PTR_W-2], rgray_i[PTR_W-3:0]});
  assign wr_en_o  = push_i && !full_o;
  assign waddr_o  = wbin_q[ADDR_W-1:0];
  assign wbin_nx  = wbin_q + PTR_W'(1);
  assign clr_edge = clr_tgl_i ^ clr_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      clr_d_q <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      clr_d_q <= clr_tgl_i;
      if (wr_en_o) begin
        wbin_q  <= wbin_nx;
        wgray_o <= PTR_W'(bin2gray(32'(wbin_nx)));
      end
      if (push_i && full_o) ovf_o <= 1'b1;  // set wins over clear
      else if (clr_edge)    ovf_o <= 1'b0;
    end
  end

  assert_ovf_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> ovf_o);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_edge) |=> ovf_o);
  assert_wgray_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
endmodule

// File: rtl/cpf_rside.sv
module cpf_rside
  import cpf_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic [PTR_W-1:0]  wgray_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [PTR_W-1:0]  rgray_o,
  output logic              empty_o
);
  logic [PTR_W-1:0] rbin_q, rbin_nx;
  logic             do_pop;

  assign empty_o = (rgray_o == wgray_i);
  assign do_pop  = pop_i && !empty_o;
  assign raddr_o = rbin_q[ADDR_W-1:0];
  assign rbin_nx = rbin_q + PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
    end else if (do_pop) begin
      rbin_q  <= rbin_nx;
      rgray_o <= PTR_W'(bin2gray(32'(rbin_nx)));
    end
  end

  assert_rptr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !empty_o) |=> $stable(rgray_o));
  assert_rgray_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_o ^ $past(rgray_o)) <= 1);
endmodule

// File: rtl/cdc_pack_fifo.sv
module cdc_pack_fifo
  import cpf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic        wclk_i,
  input  logic        rclk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_data_i,
  output logic        full_o,
  output logic        word_valid_o,
  output logic [15:0] word_data_o,
  input  logic        word_ready_i,
  output logic        empty_o,
  output logic        ovf_o,
  input  logic        ovf_clr_i
);
  logic              pk_valid;
  word_t             pk_data;
  logic              wr_en;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_rs, rgray_ws;
  logic              clr_tgl_q, clr_tgl_ws, ovf_w;
  word_t             mem [DEPTH];

  cpf_packer u_pack (
    .clk_i(wclk_i), .rst_ni(rst_ni),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .word_valid_o(pk_valid), .word_data_o(pk_data)
  );

  cpf_wside #(.ADDR_W(ADDR_W)) u_wside (
    .clk_i(wclk_i), .rst_ni(rst_ni), .push_i(pk_valid),
    .rgray_i(rgray_ws), .clr_tgl_i(clr_tgl_ws),
    .wr_en_o(wr_en), .waddr_o(waddr), .wgray_o(wgray),
    .full_o(full_o), .ovf_o(ovf_w)
  );

  cpf_rside #(.ADDR_W(ADDR_W)) u_rside (
    .clk_i(rclk_i), .rst_ni(rst_ni), .pop_i(word_ready_i),
    .wgray_i(wgray_rs), .raddr_o(raddr), .rgray_o(rgray), .empty_o(empty_o)
  );

  cpf_sync #(.W(PTR_W)) u_sync_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs));
  cpf_sync #(.W(PTR_W)) u_sync_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws));
  cpf_sync #(.W(1))     u_sync_clr (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(clr_tgl_q), .q_o(clr_tgl_ws));
  cpf_sync #(.W(1))     u_sync_ovf (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(ovf_w), .q_o(ovf_o));

  // clear request crosses as a level toggle
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)        clr_tgl_q <= 1'b0;
    else if (ovf_clr_i) clr_tgl_q <= ~clr_tgl_q;
  end

  always_ff @(posedge wclk_i) begin
    if (wr_en) mem[waddr] <= pk_data;
  end

  assign word_data_o  = mem[raddr];
  assign word_valid_o = !empty_o;
endmodule

// File: tb/sim_cdc_pack_fifo.sv
`timescale 1ns/100ps
module sim_cdc_pack_fifo;
  localparam int DEPTH = 16;

  logic        wclk_i = 0, rclk_i = 0, rst_ni = 0;
  logic        byte_valid_i = 0;
  logic [7:0]  byte_data_i = 0;
  logic        full_o, word_valid_o, empty_o, ovf_o;
  logic [15:0] word_data_o;
  logic        word_ready_i = 0, ovf_clr_i = 0;

  int n_checks = 0, n_err = 0;
  int rmode = 0;
  logic [15:0] exp_q[$];
  logic        have_lo = 0;
  logic [7:0]  lo_b = 0;
  int          keep_words = -1;

  cdc_pack_fifo #(.DEPTH(DEPTH)) u0 (.*);

  always #2 rclk_i = ~rclk_i;
  initial begin #1.3; forever #4 wclk_i = ~wclk_i; end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ready pattern generator
  int rcnt = 0;
  always @(posedge rclk_i) begin
    #0.5;
    rcnt++;
    case (rmode)
      0: word_ready_i = 0;
      1: word_ready_i = 1;
      2: word_ready_i = (rcnt % 3) != 0;
      default: word_ready_i = rcnt[2];
    endcase
  end

  // monitor: handshake completes at next posedge
  always @(negedge rclk_i) begin
    if (rst_ni) begin
      check("R8 valid vs empty", word_valid_o, !empty_o);
      if (word_valid_o && word_ready_i) begin
        if (exp_q.size() == 0) check("R3 unexpected word", word_data_o, 32'hDEAD);
        else check("R2/R3 word", word_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge wclk_i);
    byte_valid_i = 1;
    byte_data_i  = b;
    if (have_lo) begin
      if (keep_words != 0) exp_q.push_back({b, lo_b});
      if (keep_words > 0) keep_words--;
      have_lo = 0;
    end else begin
      lo_b    = b;
      have_lo = 1;
    end
    @(negedge wclk_i);
    byte_valid_i = 0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(posedge rclk_i); t++; end
    repeat (20) @(posedge rclk_i);
    @(negedge rclk_i);
    check(req, exp_q.size(), 0);
    check("R8 empty after drain", empty_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge rclk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (5) @(posedge rclk_i);
    @(negedge rclk_i);
    check("R1 empty_o", empty_o, 1);
    check("R1 full_o", full_o, 0);
    check("R1 ovf_o", ovf_o, 0);
    check("R1 word_valid_o", word_valid_o, 0);
    rst_ni = 1;
    repeat (5) @(posedge rclk_i);

    // steady stream, consumer always ready
    rmode = 1;
    for (int i = 0; i < 20; i++) send_byte(8'(i * 7 + 1));
    drain("R3 stream all delivered");

    // throttled consumer, gappy source
    rmode = 2;
    for (int i = 0; i < 64; i++) begin
      if ($urandom % 2 == 0) @(negedge wclk_i);
      send_byte(8'($urandom));
    end
    drain("R3 throttled delivered");

    rmode = 3;
    for (int i = 0; i < 48; i++) send_byte(i[0] ? 8'hA5 : 8'h5A);
    drain("R3 pattern delivered");

    // lone byte is held
    rmode = 1;
    send_byte(8'h11);
    repeat (40) @(posedge rclk_i);
    @(negedge rclk_i);
    check("R7 lone byte no word", empty_o, 1);
    check("R7 lone byte valid low", word_valid_o, 0);
    send_byte(8'h22);
    drain("R7 pair completes as 2211");

    // overflow: consumer stalled, 4 words too many
    rmode = 0;
    repeat (5) @(posedge rclk_i);
    keep_words = DEPTH;
    for (int i = 0; i < 2 * (DEPTH + 4); i++) send_byte(8'(8'h80 + i));
    keep_words = -1;
    repeat (30) @(posedge rclk_i);
    @(negedge rclk_i);
    check("R4 full when DEPTH stored", full_o, 1);
    check("R5 ovf set", ovf_o, 1);
    check("R8 data present", empty_o, 0);
    repeat (50) @(posedge rclk_i);
    @(negedge rclk_i);
    check("R6 ovf sticky", ovf_o, 1);
    @(posedge rclk_i); #0.5 ovf_clr_i = 1;
    @(posedge rclk_i); #0.5 ovf_clr_i = 0;
    repeat (30) @(posedge rclk_i);
    @(negedge rclk_i);
    check("R6 ovf cleared", ovf_o, 0);
    rmode = 1;
    drain("R5 stored words intact");
    repeat (10) @(posedge rclk_i);
    @(negedge rclk_i);
    check("R4 full cleared", full_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule